// File: doc/BRIEF.md
# Serial Crosspoint Map Loader

This controller writes a complete connection map into a chain of serially loaded 16x16 crosspoint switch devices. A host presents the map as one wide parallel word and pulses a start request. The controller captures the word, streams it out on a serial data line with a generated serial clock, and then pulses an active-low transfer strobe that moves the shifted bits into the devices' switch latches. A one-cycle done pulse marks the end of the load.

The devices sample serial data on the rising serial clock edge. The controller changes data only on the falling edge, so each bit has half a serial period of setup and of hold. The serial clock rate comes from the system clock through a half-period divider. Parameter checks at elaboration reject any setting whose real serial rate falls outside 20 kHz to 5 MHz. They also reject a strobe shorter than one serial period or one that would end later than 5 ms after the last bit.

Map layout: bit `map_i[d*256 + r*16 + c]` closes the switch at row r, column c of device d. Device 0 sits next to the controller; device N_DEV-1 is the far end of the chain.

Top module: `xpt_load_ctrl`

## Requirements
- R1: After reset and whenever busy_o is low, sclk_o and sdata_o are 0, strobe_n_o is 1 and done_o is 0 except in its single pulse cycle.
- R2: Each load produces exactly 256*N_DEV rising edges of sclk_o.
- R3: Bit k of the stream (k = 0 first) is the map bit for device N_DEV-1 down to 0, row 15 down to 0, column 15 down to 0, with column varying fastest. With the layout above this is map_i[256*N_DEV-1-k].
- R4: sdata_o never changes while sclk_o stays high; it changes only together with a falling edge of sclk_o or at load start.
- R5: Every low and every high phase of sclk_o during a load lasts exactly HALF system cycles, HALF = ceil(CLK_HZ / (2*SCLK_HZ)). The first phase counts from the cycle in which busy_o rises.
- R6: strobe_n_o falls on the same clock edge as the final falling edge of sclk_o, and sclk_o stays low while strobe_n_o is low.
- R7: strobe_n_o stays low for exactly STROBE_CYC system cycles.
- R8: done_o is high for exactly one cycle. That cycle is the first one with strobe_n_o high again, and busy_o is already low in it.
- R9: A start_i pulse while busy_o is high is ignored. The stream is unchanged and no second load follows.
- R10: busy_o rises on the first clock edge that samples start_i high while idle, and map_i is captured on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, sampled when idle |
| map_i | input | 256*N_DEV | Connection map, layout as above |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sdata_o | output | 1 | Serial data to first device |
| sclk_o | output | 1 | Serial clock, devices sample on rise |
| strobe_n_o | output | 1 | Active-low transfer strobe |

## Verification
A start sampled at edge E0 shows busy_o one cycle later. Bit j is driven from E0+2jHALF and rises at E0+(2j+1)HALF. After 256*N_DEV bits the strobe falls at E0+2*256*N_DEV*HALF, and strobe release with done follows STROBE_CYC cycles after that. The bench samples every output on the falling system clock edge. It measures each phase length and strobe length against its own HALF and STROBE_CYC, and records sdata_o at every observed rising sclk_o sample. Its checks run only after done has been seen, against an expected stream rebuilt by looping over device, row and column.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int ROWS  = 16;
  localparam int COLS  = 16;
  localparam int CELLS = ROWS * COLS;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_SHIFT  = 2'd1,
    XS_STROBE = 2'd2
  } xpt_state_e;

  // system cycles per serial clock half period, rounded up so the
  // achieved rate never exceeds the requested one
  function automatic int half_period_cycles(int clk_hz, int sclk_hz);
    return (clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
  endfunction

  function automatic int achieved_sclk_hz(int clk_hz, int half);
    return clk_hz / (2 * half);
  endfunction

  // system cycles in 5 ms
  function automatic int deadline_cycles(int clk_hz);
    return clk_hz / 200;
  endfunction

  // position of a switch bit inside the parallel map word
  function automatic int cell_index(int dev, int row, int col);
    return dev * CELLS + row * COLS + col;
  endfunction

endpackage

// File: rtl/xpt_half_timer.sv
module xpt_half_timer #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (HALF > 1) begin : g_spacing
      // R5: ticks are separated by HALF cycles, never back to back
      p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/xpt_shifter.sv
module xpt_shifter #(
  parameter int NB = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [NB-1:0] map_i,
  input  logic          shift_i,
  output logic          bit_o,
  output logic          last_o
);
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0] sreg_q;
  logic [CW-1:0] idx_q;

  assign bit_o  = sreg_q[NB-1];
  assign last_o = (idx_q == CW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      sreg_q <= map_i;
      idx_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[NB-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  // R2: never advance past the final bit of the stream
  p_shift_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !last_o);

  // R10: capture and advance never coincide
  p_load_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));

endmodule

// File: rtl/xpt_strobe.sv
module xpt_strobe #(
  parameter int LOW_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic strobe_n_o,
  output logic release_o,
  output logic done_o
);
  localparam int CW = $clog2(LOW_CYC + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign release_o  = active_q && (cnt_q == CW'(LOW_CYC - 1));
  assign strobe_n_o = !active_q;
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= release_o;
      if (fire_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (release_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: a new strobe is never requested while one is running
  p_fire_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> !active_q);

  // R8: completion comes with the strobe's return to high
  p_done_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (strobe_n_o && !$past(strobe_n_o)));

endmodule

// File: rtl/xpt_load_ctrl.sv
module xpt_load_ctrl #(
  parameter int N_DEV      = 2,
  parameter int CLK_HZ     = 50_000_000,
  parameter int SCLK_HZ    = 5_000_000,
  parameter int STROBE_CYC = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [xpt_pkg::CELLS*N_DEV-1:0] map_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          sdata_o,
  output logic                          sclk_o,
  output logic                          strobe_n_o
);
  import xpt_pkg::*;

  localparam int NB       = CELLS * N_DEV;
  localparam int HALF     = half_period_cycles(CLK_HZ, SCLK_HZ);
  localparam int REAL_HZ  = achieved_sclk_hz(CLK_HZ, HALF);
  localparam int DEADLINE = deadline_cycles(CLK_HZ);

  // elaboration-time legality of the parameter set
  generate
    if (N_DEV < 1) begin : g_bad_chain
      $error("xpt_load_ctrl: chain length must be at least one");
    end
    if (SCLK_HZ < 20_000 || SCLK_HZ > 5_000_000) begin : g_bad_req
      $error("xpt_load_ctrl: requested serial rate outside 20 kHz .. 5 MHz");
    end
    if (REAL_HZ < 20_000 || REAL_HZ > 5_000_000) begin : g_bad_real
      $error("xpt_load_ctrl: achieved serial rate outside 20 kHz .. 5 MHz");
    end
    if (STROBE_CYC < 2 * HALF) begin : g_short_strobe
      $error("xpt_load_ctrl: strobe shorter than one serial period");
    end
    if (STROBE_CYC > DEADLINE) begin : g_late_strobe
      $error("xpt_load_ctrl: strobe would end after the 5 ms deadline");
    end
  endgenerate

  xpt_state_e state_q;
  logic       sclk_q;

  // named internal events
  logic tick;
  logic cur_bit;
  logic last_bit;
  logic load_evt;
  logic rise_evt;
  logic fall_evt;
  logic shift_evt;
  logic final_evt;
  logic strobe_release;
  logic in_shift;

  assign in_shift  = (state_q == XS_SHIFT);
  assign load_evt  = (state_q == XS_IDLE) && start_i;
  assign rise_evt  = in_shift && tick && !sclk_q;
  assign fall_evt  = in_shift && tick && sclk_q;
  assign shift_evt = fall_evt && !last_bit;
  assign final_evt = fall_evt && last_bit;

  xpt_half_timer #(.HALF(HALF)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (in_shift),
    .tick_o (tick)
  );

  xpt_shifter #(.NB(NB)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_evt),
    .map_i   (map_i),
    .shift_i (shift_evt),
    .bit_o   (cur_bit),
    .last_o  (last_bit)
  );

  xpt_strobe #(.LOW_CYC(STROBE_CYC)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (final_evt),
    .strobe_n_o (strobe_n_o),
    .release_o  (strobe_release),
    .done_o     (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      sclk_q  <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          sclk_q <= 1'b0;
          if (load_evt) state_q <= XS_SHIFT;
        end
        XS_SHIFT: begin
          if (rise_evt) sclk_q <= 1'b1;
          if (fall_evt) sclk_q <= 1'b0;
          if (final_evt) state_q <= XS_STROBE;
        end
        XS_STROBE: begin
          sclk_q <= 1'b0;
          if (strobe_release) state_q <= XS_IDLE;
        end
        default: begin
          sclk_q  <= 1'b0;
          state_q <= XS_IDLE;
        end
      endcase
    end
  end

  assign busy_o  = (state_q != XS_IDLE);
  assign sclk_o  = sclk_q;
  assign sdata_o = in_shift && cur_bit;

  // R1: idle outputs rest at their quiet levels
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !sdata_o && strobe_n_o));

  // R4: data holds while the serial clock is high
  p_sdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // R5: the serial clock only moves on a divider tick
  p_sclk_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != $past(sclk_o)) && $past(busy_o) |-> $past(tick));

  // R6: strobe falls together with the final serial clock fall
  p_strobe_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n_o) |-> $fell(sclk_o));

  // R6: no serial clock activity while the strobe is low
  p_strobe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |-> !sclk_o);

  // R8: done is a single cycle and the block is idle by then
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && strobe_n_o));

  // R9: a start request while busy does not end the load
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shift && start_i) |=> busy_o);

  // R10: a load only begins from a sampled start request
  p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

endmodule

// File: tb/xpt_load_ctrl_bench.sv
module xpt_load_ctrl_bench;
  localparam int N_DEV      = 2;
  localparam int NB         = 256 * N_DEV;
  localparam int CLK_HZ     = 50_000_000;
  localparam int SCLK_HZ    = 5_000_000;
  localparam int STROBE_CYC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NB-1:0] map_i = '0;
  logic          busy_o, done_o, sdata_o, sclk_o, strobe_n_o;

  int errors = 0;
  int checks = 0;

  xpt_load_ctrl #(
    .N_DEV(N_DEV), .CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .STROBE_CYC(STROBE_CYC)
  ) u_xpt_load_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .map_i(map_i),
    .busy_o(busy_o), .done_o(done_o), .sdata_o(sdata_o),
    .sclk_o(sclk_o), .strobe_n_o(strobe_n_o)
  );

  always #10 clk = ~clk;

  // smallest half period whose rate does not exceed the request
  function automatic int bench_half();
    int h = 1;
    while (CLK_HZ / (2 * h) > SCLK_HZ) h++;
    return h;
  endfunction

  localparam int HALF = bench_half();

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state, sampled on the falling system edge
  bit cap [NB];
  int rises, run, phase_viol, stable_viol, strobe_clk_viol, strobe_late;
  int strobe_falls, strobe_run, last_strobe_len, done_cnt, done_viol, busy_rises;
  logic prev_sclk = 1'b0, prev_sdata = 1'b0, prev_strobe = 1'b1, prev_busy = 1'b0;

  task automatic clear_monitor();
    rises = 0; run = 0; phase_viol = 0; stable_viol = 0; strobe_clk_viol = 0;
    strobe_late = 0; strobe_falls = 0; strobe_run = 0; last_strobe_len = -1;
    done_cnt = 0; done_viol = 0; busy_rises = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o && !prev_busy) begin
        busy_rises++;
        run = 1;
      end else if (sclk_o != prev_sclk) begin
        if (run != HALF) phase_viol++;
        run = 1;
        if (sclk_o) begin
          if (rises < NB) cap[rises] = sdata_o;
          rises++;
        end
      end else begin
        run++;
      end
      if (sclk_o && prev_sclk && sdata_o != prev_sdata) stable_viol++;
      if (!strobe_n_o) begin
        strobe_run++;
        if (sclk_o) strobe_clk_viol++;
      end
      if (!strobe_n_o && prev_strobe) begin
        strobe_falls++;
        if (!(prev_sclk && !sclk_o) || rises != NB) strobe_late++;
      end
      if (strobe_n_o && !prev_strobe) begin
        last_strobe_len = strobe_run;
        strobe_run = 0;
        if (!done_o || busy_o) done_viol++;
      end
      if (done_o) done_cnt++;
      prev_sclk = sclk_o; prev_sdata = sdata_o; prev_strobe = strobe_n_o; prev_busy = busy_o;
    end
  end

  task automatic check_idle(input string when_s);
    check(!sclk_o && !sdata_o && strobe_n_o && !busy_o && !done_o,
          {"R1 idle levels ", when_s},
          {27'd0, sclk_o, sdata_o, strobe_n_o, busy_o, done_o}, 5'b00100);
  endtask

  task automatic run_load(input logic [NB-1:0] m, input bit inject, input string name);
    bit exp [NB];
    int k = 0;
    int mism = 0;
    int first_bad = -1;
    int waited = 0;
    for (int d = N_DEV - 1; d >= 0; d--)
      for (int r = 15; r >= 0; r--)
        for (int c = 15; c >= 0; c--) begin
          exp[k] = m[d * 256 + r * 16 + c];
          k++;
        end
    @(negedge clk); #1;
    clear_monitor();
    map_i = m;
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    check(busy_o == 1'b1, {"R10 busy one cycle after start ", name}, int'(busy_o), 1);
    if (inject) begin
      repeat (300) @(negedge clk);
      #1;
      map_i = ~m;
      start_i = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0;
    end
    while (done_cnt == 0 && waited < 20000) begin
      @(negedge clk); #2;
      waited++;
    end
    check(waited < 20000, {"R8 done seen ", name}, waited, 0);
    if (inject) begin
      @(negedge clk); #1;
      map_i = ~m;
      start_i = 1'b0;
    end
    repeat (40) @(negedge clk);
    #1;
    for (int i = 0; i < NB; i++)
      if (cap[i] != exp[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    check(rises == NB, {"R2 bit count ", name}, rises, NB);
    check(mism == 0, {"R3 stream order ", name}, first_bad, -1);
    check(stable_viol == 0, {"R4 data stable while high ", name}, stable_viol, 0);
    check(phase_viol == 0, {"R5 phase length ", name}, phase_viol, 0);
    check(strobe_falls == 1 && strobe_late == 0 && strobe_clk_viol == 0,
          {"R6 strobe placement ", name}, strobe_late + strobe_clk_viol, 0);
    check(last_strobe_len == STROBE_CYC, {"R7 strobe width ", name}, last_strobe_len, STROBE_CYC);
    check(done_cnt == 1 && done_viol == 0, {"R8 done pulse ", name}, done_cnt, 1);
    check(busy_rises == 1, {"R9 single load ", name}, busy_rises, 1);
    check_idle({"after ", name});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0] m;
    void'($urandom(32'd20240611));
    clear_monitor();
    repeat (4) @(negedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_idle("after reset");

    run_load('0, 1'b0, "all open");
    run_load('1, 1'b0, "all closed");
    m = '0; m[NB-1] = 1'b1;
    run_load(m, 1'b0, "far corner first");
    m = '0; m[0] = 1'b1;
    run_load(m, 1'b0, "near corner last");
    m = '0; m[256 + 15 * 16 + 3] = 1'b1; m[2 * 16 + 14] = 1'b1;
    run_load(m, 1'b0, "two cells");
    for (int n = 0; n < 4; n++) begin
      for (int w = 0; w < NB / 32; w++) m[w * 32 +: 32] = $urandom;
      run_load(m, 1'b0, $sformatf("random %0d", n));
    end
    for (int w = 0; w < NB / 32; w++) m[w * 32 +: 32] = $urandom;
    run_load(m, 1'b1, "start while busy");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule